// File: doc/BRIEF.md
# Receive Route Table with Wildcard Matching

This block holds a small set of receive routes for a bridge between a UDP/IP stack and an on-chip bus. Each route ties a triple (source IP address, destination UDP port, source UDP port) to a bus address on the chip side. Agents on the bus add routes by sending a four-word receive configuration. The block answers each configuration with a request for an acknowledge word, or for a negative acknowledge word if no slot is left, sent to the bus address named in the configuration.

The lookup side handles traffic coming in from the network. The stack presents the source IP and both ports of an arriving datagram. After a fixed latency the block returns a strobe, a hit flag and the bus address the payload should go to. Any stored field that is all ones acts as a wildcard. When several routes match, the one in the lowest slot wins. When none matches, the caller drops the datagram.

Top module: `rxroute_table`

## Requirements
- R1: After reset every slot is empty, a lookup reports a miss, and no response request is raised.
- R2: A configuration is a word whose bits 31..28 equal 0x3 (bits 27..0 ignored), then a word holding the source IP, then a word with the destination port in bits 31..16 and the source port in bits 15..0, then a word holding the target bus address. One word is taken per cycle while `cfg_valid` is high.
- R3: When the fourth word is taken and a slot is free, the route is written into the lowest free slot. In the next cycle `rsp_valid` pulses for one cycle with `rsp_word` = 0x50000000 (ack, bit 27 = 0) and `rsp_dest` = the target bus address.
- R4: When the fourth word is taken and all slots are full, nothing is stored. In the next cycle `rsp_valid` pulses with `rsp_word` = 0x60000000 (nack, bit 27 = 0) and `rsp_dest` = the target bus address.
- R5: A lookup with `lk_valid` high returns `res_valid` exactly LOOKUP_LAT cycles later (1 + PIPE_REG, 1 by default). `res_hit` is 1 and `res_addr` is the route's address when all three fields equal a stored route.
- R6: A stored field that is all ones (IP 0xFFFFFFFF, port 0xFFFF) matches any incoming value in that field. The other fields of the route must still match.
- R7: When no valid route matches, `res_hit` is 0 and `res_addr` is 0.
- R8: When several valid routes match, the address of the lowest-index slot is returned.
- R9: A word whose bits 31..28 are not 0x3 that arrives while no configuration is in progress is ignored: no response is raised and no route is added.
- R10: Once a slot is valid it is never overwritten. A configuration rejected because the table is full does not change any lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word strobe |
| cfg_word | input | 32 | Configuration word |
| rsp_valid | output | 1 | Ack/nack request strobe |
| rsp_word | output | 32 | Ack or nack word |
| rsp_dest | output | ADDR_W | Bus address the response goes to |
| lk_valid | input | 1 | Lookup request strobe |
| lk_src_ip | input | 32 | Source IP of the arriving datagram |
| lk_dst_port | input | 16 | Destination UDP port of the datagram |
| lk_src_port | input | 16 | Source UDP port of the datagram |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | A route matched |
| res_addr | output | ADDR_W | Delivery bus address, 0 on a miss |

## Verification
The bench goes after overlapping routes. One datagram matches both a wildcard-port route and a wildcard-IP route, so a priority encoder that lets the highest slot win returns the wrong address. Near-miss datagrams differ from a stored route in a single field, which exposes a comparator that ignores a field or treats any value as a wildcard. A configuration sent to a full table must produce a nack and leave lookups unchanged; an allocator that wraps around would overwrite slot 0 and reroute traffic. A stray non-configuration word checks that the parser does not start a sequence on the wrong type code, and a second reset checks that every slot is emptied.

// File: rtl/rxroute_pkg.sv
package rxroute_pkg;
   localparam int WORD_W = 32;
   localparam int IP_W   = 32;
   localparam int PORT_W = 16;

   localparam logic [3:0] TYPE_RXCFG = 4'h3;
   localparam logic [3:0] TYPE_ACK   = 4'h5;
   localparam logic [3:0] TYPE_NACK  = 4'h6;

   typedef enum logic [1:0] {
      PS_HDR   = 2'd0,
      PS_IP    = 2'd1,
      PS_PORTS = 2'd2,
      PS_ADDR  = 2'd3
   } parse_state_t;

   function automatic logic [WORD_W-1:0] resp_word(input logic rejected);
      return {(rejected ? TYPE_NACK : TYPE_ACK), 1'b0, 27'd0};
   endfunction
endpackage

// File: rtl/rxroute_cfg_parser.sv
module rxroute_cfg_parser
   import rxroute_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [WORD_W-1:0] cfg_word,
   output logic              wr_req,
   output logic [IP_W-1:0]   wr_ip,
   output logic [PORT_W-1:0] wr_dport,
   output logic [PORT_W-1:0] wr_sport,
   output logic [ADDR_W-1:0] wr_addr
);
   parse_state_t      state_q;
   logic [IP_W-1:0]   ip_q;
   logic [PORT_W-1:0] dport_q;
   logic [PORT_W-1:0] sport_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PS_HDR;
         ip_q    <= '0;
         dport_q <= '0;
         sport_q <= '0;
      end else if (cfg_valid) begin
         unique case (state_q)
            PS_HDR: begin
               if (cfg_word[WORD_W-1 -: 4] == TYPE_RXCFG) state_q <= PS_IP;
            end
            PS_IP: begin
               ip_q    <= cfg_word[IP_W-1:0];
               state_q <= PS_PORTS;
            end
            PS_PORTS: begin
               dport_q <= cfg_word[2*PORT_W-1:PORT_W];
               sport_q <= cfg_word[PORT_W-1:0];
               state_q <= PS_ADDR;
            end
            PS_ADDR: state_q <= PS_HDR;
            default: state_q <= PS_HDR;
         endcase
      end
   end

   assign wr_req   = cfg_valid && (state_q == PS_ADDR);
   assign wr_ip    = ip_q;
   assign wr_dport = dport_q;
   assign wr_sport = sport_q;
   assign wr_addr  = cfg_word[ADDR_W-1:0];

   // R9
   hdr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_HDR && cfg_valid && cfg_word[WORD_W-1 -: 4] != TYPE_RXCFG)
      |=> (state_q == PS_HDR));

   // R2
   commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> $past(state_q) == PS_PORTS || !$past(cfg_valid));
endmodule

// File: rtl/rxroute_store.sv
module rxroute_store
   import rxroute_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_req,
   input  logic [IP_W-1:0]                wr_ip,
   input  logic [PORT_W-1:0]              wr_dport,
   input  logic [PORT_W-1:0]              wr_sport,
   input  logic [ADDR_W-1:0]              wr_addr,
   output logic [ENTRIES-1:0]             tbl_valid,
   output logic [ENTRIES-1:0][IP_W-1:0]   tbl_ip,
   output logic [ENTRIES-1:0][PORT_W-1:0] tbl_dport,
   output logic [ENTRIES-1:0][PORT_W-1:0] tbl_sport,
   output logic [ENTRIES-1:0][ADDR_W-1:0] tbl_addr,
   output logic                           rsp_valid,
   output logic [WORD_W-1:0]              rsp_word,
   output logic [ADDR_W-1:0]              rsp_dest
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] valid_q;
   logic [IDX_W-1:0]   free_idx;
   logic               full;

   assign full = &valid_q;

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_idx = IDX_W'(i);
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic take;
      assign take = wr_req && !full && (free_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g]   <= 1'b0;
            tbl_ip[g]    <= '0;
            tbl_dport[g] <= '0;
            tbl_sport[g] <= '0;
            tbl_addr[g]  <= '0;
         end else if (take) begin
            valid_q[g]   <= 1'b1;
            tbl_ip[g]    <= wr_ip;
            tbl_dport[g] <= wr_dport;
            tbl_sport[g] <= wr_sport;
            tbl_addr[g]  <= wr_addr;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_word  <= '0;
         rsp_dest  <= '0;
      end else begin
         rsp_valid <= wr_req;
         if (wr_req) begin
            rsp_word <= resp_word(full);
            rsp_dest <= wr_addr;
         end
      end
   end

   assign tbl_valid = valid_q;

   // R10
   valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(valid_q) & ~valid_q) == '0);

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full) |=> $stable(valid_q));

   // R3
   rsp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_word[27:0] == '0) &&
                    (rsp_word[31:28] == TYPE_ACK || rsp_word[31:28] == TYPE_NACK));

   // R3
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/rxroute_matcher.sv
module rxroute_matcher
   import rxroute_pkg::*;
#(
   parameter int ENTRIES  = 4,
   parameter int ADDR_W   = 32,
   parameter int PIPE_REG = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           lk_valid,
   input  logic [IP_W-1:0]                lk_ip,
   input  logic [PORT_W-1:0]              lk_dport,
   input  logic [PORT_W-1:0]              lk_sport,
   input  logic [ENTRIES-1:0]             tbl_valid,
   input  logic [ENTRIES-1:0][IP_W-1:0]   tbl_ip,
   input  logic [ENTRIES-1:0][PORT_W-1:0] tbl_dport,
   input  logic [ENTRIES-1:0][PORT_W-1:0] tbl_sport,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] tbl_addr,
   output logic                           res_valid,
   output logic                           res_hit,
   output logic [ADDR_W-1:0]              res_addr
);
   localparam int LOOKUP_LAT = 1 + PIPE_REG;

   logic              k_valid;
   logic [IP_W-1:0]   k_ip;
   logic [PORT_W-1:0] k_dport;
   logic [PORT_W-1:0] k_sport;

   if (PIPE_REG != 0) begin : g_key_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            k_valid <= 1'b0;
            k_ip    <= '0;
            k_dport <= '0;
            k_sport <= '0;
         end else begin
            k_valid <= lk_valid;
            k_ip    <= lk_ip;
            k_dport <= lk_dport;
            k_sport <= lk_sport;
         end
      end
   end else begin : g_key_wire
      assign k_valid = lk_valid;
      assign k_ip    = lk_ip;
      assign k_dport = lk_dport;
      assign k_sport = lk_sport;
   end

   logic [ENTRIES-1:0] match;
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic ip_ok, dp_ok, sp_ok;
      assign ip_ok = (tbl_ip[g] == '1)    || (tbl_ip[g] == k_ip);
      assign dp_ok = (tbl_dport[g] == '1) || (tbl_dport[g] == k_dport);
      assign sp_ok = (tbl_sport[g] == '1) || (tbl_sport[g] == k_sport);
      assign match[g] = tbl_valid[g] && ip_ok && dp_ok && sp_ok;
   end

   logic              any_hit;
   logic [ADDR_W-1:0] win_addr;
   always_comb begin
      any_hit  = 1'b0;
      win_addr = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            any_hit  = 1'b1;
            win_addr = tbl_addr[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_addr  <= '0;
      end else begin
         res_valid <= k_valid;
         res_hit   <= k_valid && any_hit;
         res_addr  <= (k_valid && any_hit) ? win_addr : '0;
      end
   end

   // R7
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_addr == '0));

   // R5
   lookup_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(lk_valid, LOOKUP_LAT));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !res_hit);
endmodule

// File: rtl/rxroute_table.sv
module rxroute_table
   import rxroute_pkg::*;
#(
   parameter int ENTRIES  = 4,
   parameter int ADDR_W   = 32,
   parameter int PIPE_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [31:0]       cfg_word,
   output logic              rsp_valid,
   output logic [31:0]       rsp_word,
   output logic [ADDR_W-1:0] rsp_dest,
   input  logic              lk_valid,
   input  logic [31:0]       lk_src_ip,
   input  logic [15:0]       lk_dst_port,
   input  logic [15:0]       lk_src_port,
   output logic              res_valid,
   output logic              res_hit,
   output logic [ADDR_W-1:0] res_addr
);
   if (ENTRIES < 1 || ENTRIES > 256) begin : g_bad_entries
      $error("rxroute_table: ENTRIES must be 1..256");
   end
   if (ADDR_W < 1 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("rxroute_table: ADDR_W must be 1..32");
   end
   if (PIPE_REG != 0 && PIPE_REG != 1) begin : g_bad_pipe
      $error("rxroute_table: PIPE_REG must be 0 or 1");
   end

   logic                           wr_req;
   logic [IP_W-1:0]                wr_ip;
   logic [PORT_W-1:0]              wr_dport;
   logic [PORT_W-1:0]              wr_sport;
   logic [ADDR_W-1:0]              wr_addr;
   logic [ENTRIES-1:0]             tbl_valid;
   logic [ENTRIES-1:0][IP_W-1:0]   tbl_ip;
   logic [ENTRIES-1:0][PORT_W-1:0] tbl_dport;
   logic [ENTRIES-1:0][PORT_W-1:0] tbl_sport;
   logic [ENTRIES-1:0][ADDR_W-1:0] tbl_addr;

   rxroute_cfg_parser #(.ADDR_W(ADDR_W)) u_parser (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
      .wr_req(wr_req), .wr_ip(wr_ip), .wr_dport(wr_dport),
      .wr_sport(wr_sport), .wr_addr(wr_addr)
   );

   rxroute_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ip(wr_ip),
      .wr_dport(wr_dport), .wr_sport(wr_sport), .wr_addr(wr_addr),
      .tbl_valid(tbl_valid), .tbl_ip(tbl_ip), .tbl_dport(tbl_dport),
      .tbl_sport(tbl_sport), .tbl_addr(tbl_addr),
      .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_dest(rsp_dest)
   );

   rxroute_matcher #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PIPE_REG(PIPE_REG)) u_match (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ip(lk_src_ip),
      .lk_dport(lk_dst_port), .lk_sport(lk_src_port),
      .tbl_valid(tbl_valid), .tbl_ip(tbl_ip), .tbl_dport(tbl_dport),
      .tbl_sport(tbl_sport), .tbl_addr(tbl_addr),
      .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr)
   );

   // R1
   rst_empty_chk: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !res_valid && tbl_valid == '0));
endmodule

// File: tb/tb_rxroute_table.sv
`timescale 1ns/1ps
module tb_rxroute_table;
   localparam int ADDR_W   = 32;
   localparam int PIPE_REG = 0;
   localparam int LAT      = 1 + PIPE_REG;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_valid = 1'b0;
   logic [31:0]       cfg_word = '0;
   logic              rsp_valid;
   logic [31:0]       rsp_word;
   logic [ADDR_W-1:0] rsp_dest;
   logic              lk_valid = 1'b0;
   logic [31:0]       lk_src_ip = '0;
   logic [15:0]       lk_dst_port = '0;
   logic [15:0]       lk_src_port = '0;
   logic              res_valid;
   logic              res_hit;
   logic [ADDR_W-1:0] res_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   rxroute_table #(.ENTRIES(4), .ADDR_W(ADDR_W), .PIPE_REG(PIPE_REG)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
      .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_dest(rsp_dest),
      .lk_valid(lk_valid), .lk_src_ip(lk_src_ip), .lk_dst_port(lk_dst_port),
      .lk_src_port(lk_src_port), .res_valid(res_valid), .res_hit(res_hit),
      .res_addr(res_addr)
   );

   typedef struct packed {
      logic [31:0] ip;
      logic [15:0] dport;
      logic [15:0] sport;
      logic        hit;
      logic [31:0] addr;
      logic [3:0]  req;
   } vec_t;

   // Lookups against slots 0..2 (see directed configuration below)
   localparam vec_t VECS [8] = '{
      '{32'hC0A80001, 16'h1234, 16'h5678, 1'b1, 32'h00001000, 4'd5}, // R5 exact
      '{32'hC0A80001, 16'h1234, 16'h5679, 1'b0, 32'h00000000, 4'd7}, // R7 sport off
      '{32'h12345678, 16'h00AA, 16'h0001, 1'b1, 32'h00002000, 4'd6}, // R6 ip+sport wild
      '{32'h0A000005, 16'h0007, 16'h0009, 1'b1, 32'h00003000, 4'd6}, // R6 ports wild
      '{32'h0A000005, 16'h00AA, 16'h0000, 1'b1, 32'h00002000, 4'd8}, // R8 slots 1,2
      '{32'hC0A80001, 16'h00AA, 16'h5678, 1'b1, 32'h00002000, 4'd8}, // R8 slot 1 only
      '{32'hC0A80002, 16'h1234, 16'h5678, 1'b0, 32'h00000000, 4'd7}, // R7 ip off
      '{32'h0A000006, 16'h00AB, 16'hFFFF, 1'b0, 32'h00000000, 4'd7}  // R7 dport off
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_cfg(input logic [31:0] ip, input logic [15:0] dp,
                           input logic [15:0] sp, input logic [31:0] addr,
                           input bit exp_nack, input string req);
      logic [31:0] words [4];
      words[0] = 32'h3ABCDEF0;
      words[1] = ip;
      words[2] = {dp, sp};
      words[3] = addr;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         cfg_valid = 1'b1;
         cfg_word  = words[i];
         if (i < 3) check(rsp_valid == 1'b0, req, "early rsp", 64'(rsp_valid), 64'd0);
      end
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_word  = '0;
      check(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
      check(rsp_word == (exp_nack ? 32'h60000000 : 32'h50000000), req, "rsp_word",
            64'(rsp_word), exp_nack ? 64'h60000000 : 64'h50000000);
      check(rsp_dest == addr, req, "rsp_dest", 64'(rsp_dest), 64'(addr));
      @(negedge clk);
      check(rsp_valid == 1'b0, req, "rsp pulse end", 64'(rsp_valid), 64'd0);
   endtask

   task automatic lookup(input logic [31:0] ip, input logic [15:0] dp,
                         input logic [15:0] sp, input bit exp_hit,
                         input logic [31:0] exp_addr, input string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_src_ip = ip; lk_dst_port = dp; lk_src_port = sp;
      @(negedge clk);
      lk_valid = 1'b0;
      for (int i = 1; i < LAT; i++) @(negedge clk);
      check(res_valid == 1'b1, req, "res_valid", 64'(res_valid), 64'd1);
      check(res_hit == exp_hit, req, "res_hit", 64'(res_hit), 64'(exp_hit));
      check(res_addr == exp_addr, req, "res_addr", 64'(res_addr), 64'(exp_addr));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rsp_valid == 1'b0, "R1", "rsp after reset", 64'(rsp_valid), 64'd0);
      check(res_valid == 1'b0, "R1", "res after reset", 64'(res_valid), 64'd0);
      lookup(32'hFFFFFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 32'h0, "R1");

      // R9 stray word of another type is ignored
      @(negedge clk); cfg_valid = 1'b1; cfg_word = 32'h4000_1234;
      @(negedge clk); cfg_valid = 1'b0; cfg_word = '0;
      check(rsp_valid == 1'b0, "R9", "rsp after stray", 64'(rsp_valid), 64'd0);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R9", "rsp after stray+1", 64'(rsp_valid), 64'd0);
      lookup(32'hC0A80001, 16'h1234, 16'h5678, 1'b0, 32'h0, "R9");

      // R2 R3 fill slots 0..2
      send_cfg(32'hC0A80001, 16'h1234, 16'h5678, 32'h00001000, 1'b0, "R2");
      send_cfg(32'hFFFFFFFF, 16'h00AA, 16'hFFFF, 32'h00002000, 1'b0, "R3");
      send_cfg(32'h0A000005, 16'hFFFF, 16'hFFFF, 32'h00003000, 1'b0, "R3");

      for (int v = 0; v < 8; v++) begin
         lookup(VECS[v].ip, VECS[v].dport, VECS[v].sport, VECS[v].hit, VECS[v].addr,
                $sformatf("R%0d", VECS[v].req));
      end

      // R3 last free slot, then R4 full table
      send_cfg(32'h0B000001, 16'h0050, 16'hFFFF, 32'h00004000, 1'b0, "R3");
      send_cfg(32'h0B000001, 16'h0050, 16'h0001, 32'h00005000, 1'b1, "R4");
      // R10 rejected route did not overwrite slot 3 or slot 0
      lookup(32'h0B000001, 16'h0050, 16'h0001, 1'b1, 32'h00004000, "R10");
      lookup(32'hC0A80001, 16'h1234, 16'h5678, 1'b1, 32'h00001000, "R10");

      // R1 reset empties the table
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      lookup(32'hC0A80001, 16'h1234, 16'h5678, 1'b0, 32'h0, "R1");
      send_cfg(32'h01020304, 16'h0001, 16'h0002, 32'h00006000, 1'b0, "R1");
      lookup(32'h01020304, 16'h0001, 16'h0002, 1'b1, 32'h00006000, "R5");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule